// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block turns 32-bit virtual addresses into physical addresses through a small, fully associative table of page mappings. Each lookup compares the virtual page number against every slot in the same cycle and, on a valid match, returns the physical frame joined to the untouched 4 KiB page offset. The block does not walk page tables. When a lookup cannot be served, it reports a one-cycle exception with a handler vector and a cause code. It also records the faulting address and forms a context word that points the refill handler straight at the page table entry it needs.

The refill handler installs entries in two steps. It first loads a pending page-number register and a pending frame register, which holds the frame number, a valid flag and a dirty flag. It then issues a write-random command. The slot that receives the entry is the one named by a free-running down-counter, which gives pseudo-random replacement at almost no cost. The upper twelve bits of the context word are a page-table base that software writes.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup whose page number VA[31:12] matches a slot with its valid flag set raises `lk_hit` in the same cycle. `lk_pa` is then {frame number, VA[11:0]}. Without a hit, `lk_pa` is zero.
- R2: A lookup that matches no slot raises `exc_pulse` in the next cycle with `exc_code` = 1 and `exc_vec` = 0x8000_0000. `bad_va` then holds the full faulting address.
- R3: `ctx_word` bits 31:20 hold the last base written through `ctx_we`. Bits 19:2 hold VA[31:14] of the last refill or invalid-entry fault. Bits 1:0 are zero.
- R4: `wr_rand` copies the pending page number, frame number, valid flag and dirty flag into the slot named by `rand_idx` in that cycle. The pending values used are the ones registered before that cycle.
- R5: `rand_idx` is 15 after reset. It decreases by one every clock and goes from 0 back to 15, whatever else the block is doing.
- R6: A lookup that matches a slot whose valid flag is clear raises `exc_pulse` in the next cycle with `exc_code` = 2 and `exc_vec` = 0x8000_0180. `bad_va` then holds the faulting address.
- R7: A store lookup (`lk_store` = 1) that hits a valid slot whose dirty flag is clear raises `exc_code` = 3 with `exc_vec` = 0x8000_0180. It does not change `bad_va` or the context page field.
- R8: Reset clears every slot, so after reset no lookup hits.
- R9: When a lookup and `wr_rand` fall in the same cycle, the slot being overwritten takes no part in the match.
- R10: `exc_pulse` is high only in the cycle after a faulting lookup. `exc_code` is 0 and `exc_vec` is 0 in every other cycle.
- R11: `bad_va` changes only in the cycle after a refill or invalid-entry fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_store | input | 1 | Lookup is for a store |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_pa | output | 32 | Translated physical address |
| hi_we | input | 1 | Load the pending page number |
| hi_vpn | input | 20 | Pending virtual page number |
| lo_we | input | 1 | Load the pending frame word |
| lo_pfn | input | 20 | Pending physical frame number |
| lo_valid | input | 1 | Pending valid flag |
| lo_dirty | input | 1 | Pending dirty (writable) flag |
| wr_rand | input | 1 | Install the pending entry at `rand_idx` |
| ctx_we | input | 1 | Load the context base |
| ctx_base | input | 12 | Page-table base for context bits 31:20 |
| rand_idx | output | 4 | Current replacement counter |
| exc_pulse | output | 1 | One-cycle exception indication |
| exc_code | output | 2 | Cause: 0 none, 1 refill, 2 invalid, 3 modify |
| exc_vec | output | 32 | Handler vector for the exception |
| bad_va | output | 32 | Last faulting virtual address |
| ctx_word | output | 32 | Context pointer to the page table entry |

## Verification
The bench uses the default build: 16 slots with a 4-bit counter. At that size the counter wraps many times within a short run. Because the counter keeps running on its own, random fills land on every slot and overwrite live entries. A directed same-cycle install and lookup on the counter's current slot is also easy to set up. A small pool of page numbers keeps hits, misses, invalid matches and clean-page stores all frequent.

// File: rtl/xlat_pkg.sv
// Shared widths, cause codes and slot layout for the translation buffer.
package xlat_pkg;
    localparam int VA_W    = 32;
    localparam int PG_BITS = 12;
    localparam int VPN_W   = VA_W - PG_BITS;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'd0,
        EXC_REFILL  = 2'd1,
        EXC_INVALID = 2'd2,
        EXC_MODIFY  = 2'd3
    } exc_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] pfn;
        logic             valid;
        logic             dirty;
    } slot_t;
endpackage

// File: rtl/xlat_rand.sv
// Free-running replacement counter: counts down from N-1 to 0 and wraps.
// Assumes N >= 2. It ignores all table activity.
module xlat_rand #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] TOP = IW'(N - 1);

    // Decrement every clock, wrap at zero
    always_ff @(posedge clk) begin
        if (!rst_n)           idx <= TOP;
        else if (idx == '0)   idx <= TOP;
        else                  idx <= idx - 1'b1;
    end
endmodule

// File: rtl/xlat_cam.sv
// Slot storage with a parallel page-number compare.
// Assumes software keeps page numbers unique; if two slots match, the lowest index wins.
// The slot being written this cycle is masked out of the compare.
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  slot_t            wr_slot,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             m_any,
    output slot_t            m_slot
);
    slot_t        ents [N];
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_ent
        slot_t ent;

        // Hold one slot; reset clears it, wr_en at this index loads it
        always_ff @(posedge clk) begin
            if (!rst_n)                           ent <= '0;
            else if (wr_en && wr_idx == IW'(g))   ent <= wr_slot;
        end

        assign ents[g] = ent;
        assign eq[g]   = (ent.vpn == lk_vpn) && !(wr_en && wr_idx == IW'(g));
    end

    // Select the lowest matching slot
    always_comb begin
        m_any  = |eq;
        m_slot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) m_slot = ents[i];
        end
    end
endmodule

// File: rtl/xlat_fault.sv
// Registers the exception pulse, cause and vector one cycle after a lookup.
// Captures the bad address and context page field on refill or invalid faults only.
module xlat_fault
    import xlat_pkg::*;
#(
    parameter logic [31:0] REFILL_VEC = 32'h8000_0000,
    parameter logic [31:0] GEN_VEC    = 32'h8000_0180
) (
    input  logic        clk,
    input  logic        rst_n,
    input  exc_e        cause,
    input  logic [31:0] va,
    input  logic        base_we,
    input  logic [11:0] base_in,
    output logic        exc_pulse,
    output logic [1:0]  exc_code,
    output logic [31:0] exc_vec,
    output logic [31:0] bad_va,
    output logic [31:0] ctx_word
);
    exc_e        code_q;
    logic [11:0] base_q;
    logic [17:0] cvpn_q;

    // Exception outputs and fault-address capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_pulse <= 1'b0;
            code_q    <= EXC_NONE;
            exc_vec   <= '0;
            bad_va    <= '0;
            cvpn_q    <= '0;
            base_q    <= '0;
        end else begin
            exc_pulse <= (cause != EXC_NONE);
            code_q    <= cause;
            case (cause)
                EXC_NONE:   exc_vec <= '0;
                EXC_REFILL: exc_vec <= REFILL_VEC;
                default:    exc_vec <= GEN_VEC;
            endcase
            if (cause == EXC_REFILL || cause == EXC_INVALID) begin
                bad_va <= va;
                cvpn_q <= va[31:14];
            end
            if (base_we) base_q <= base_in;
        end
    end

    assign exc_code = code_q;
    assign ctx_word = {base_q, cvpn_q, 2'b00};
endmodule

// File: rtl/xlat_buffer.sv
// Top of the translation buffer: pending entry registers, lookup classification,
// and glue between the counter, slot storage and fault unit.
// Assumes at most one lookup per cycle and 4 KiB pages.
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int          N          = 16,
    parameter int          IW         = $clog2(N),
    parameter logic [31:0] REFILL_VEC = 32'h8000_0000,
    parameter logic [31:0] GEN_VEC    = 32'h8000_0180
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_req,
    input  logic          lk_store,
    input  logic [31:0]   lk_va,
    output logic          lk_hit,
    output logic [31:0]   lk_pa,
    input  logic          hi_we,
    input  logic [19:0]   hi_vpn,
    input  logic          lo_we,
    input  logic [19:0]   lo_pfn,
    input  logic          lo_valid,
    input  logic          lo_dirty,
    input  logic          wr_rand,
    input  logic          ctx_we,
    input  logic [11:0]   ctx_base,
    output logic [IW-1:0] rand_idx,
    output logic          exc_pulse,
    output logic [1:0]    exc_code,
    output logic [31:0]   exc_vec,
    output logic [31:0]   bad_va,
    output logic [31:0]   ctx_word
);
    slot_t pend;
    slot_t m_slot;
    logic  m_any;
    exc_e  cause;

    // Pending entry halves, loaded separately by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            if (hi_we) pend.vpn <= hi_vpn;
            if (lo_we) begin
                pend.pfn   <= lo_pfn;
                pend.valid <= lo_valid;
                pend.dirty <= lo_dirty;
            end
        end
    end

    xlat_rand #(.N(N), .IW(IW)) u_rand (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (rand_idx)
    );

    xlat_cam #(.N(N), .IW(IW)) u_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_rand),
        .wr_idx  (rand_idx),
        .wr_slot (pend),
        .lk_vpn  (lk_va[31:PG_BITS]),
        .m_any   (m_any),
        .m_slot  (m_slot)
    );

    // Classify the lookup outcome
    always_comb begin
        cause = EXC_NONE;
        if (lk_req) begin
            if (!m_any)                            cause = EXC_REFILL;
            else if (!m_slot.valid)                cause = EXC_INVALID;
            else if (lk_store && !m_slot.dirty)    cause = EXC_MODIFY;
        end
    end

    assign lk_hit = lk_req && m_any && m_slot.valid;
    assign lk_pa  = lk_hit ? {m_slot.pfn, lk_va[PG_BITS-1:0]} : '0;

    xlat_fault #(.REFILL_VEC(REFILL_VEC), .GEN_VEC(GEN_VEC)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause     (cause),
        .va        (lk_va),
        .base_we   (ctx_we),
        .base_in   (ctx_base),
        .exc_pulse (exc_pulse),
        .exc_code  (exc_code),
        .exc_vec   (exc_vec),
        .bad_va    (bad_va),
        .ctx_word  (ctx_word)
    );
endmodule

// File: rtl/xlat_chk.sv
// Port-level temporal checks for xlat_buffer, attached by bind.
module xlat_chk #(
    parameter int          N          = 16,
    parameter int          IW         = $clog2(N),
    parameter logic [31:0] REFILL_VEC = 32'h8000_0000,
    parameter logic [31:0] GEN_VEC    = 32'h8000_0180
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_req,
    input logic [31:0]   lk_va,
    input logic [IW-1:0] rand_idx,
    input logic          exc_pulse,
    input logic [1:0]    exc_code,
    input logic [31:0]   exc_vec,
    input logic [31:0]   bad_va
);
    // R5
    rand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rand_idx == (($past(rand_idx) == '0) ? IW'(N - 1) : $past(rand_idx) - 1'b1));

    // R10
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && exc_pulse) |-> $past(lk_req));

    // R2
    refill_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && exc_code == 2'd1) |-> (exc_vec == REFILL_VEC && bad_va == $past(lk_va)));

    // R6
    invalid_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && exc_code == 2'd2) |-> (exc_vec == GEN_VEC && bad_va == $past(lk_va)));

    // R7
    modify_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && exc_code == 2'd3) |-> (exc_vec == GEN_VEC && $stable(bad_va)));

    // R11
    bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && exc_code != 2'd1 && exc_code != 2'd2) |-> $stable(bad_va));
endmodule

bind xlat_buffer xlat_chk #(
    .N(N), .IW(IW), .REFILL_VEC(REFILL_VEC), .GEN_VEC(GEN_VEC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_va     (lk_va),
    .rand_idx  (rand_idx),
    .exc_pulse (exc_pulse),
    .exc_code  (exc_code),
    .exc_vec   (exc_vec),
    .bad_va    (bad_va)
);

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 0, lk_store = 0, hi_we = 0, lo_we = 0;
    logic        lo_valid = 0, lo_dirty = 0, wr_rand = 0, ctx_we = 0;
    logic [31:0] lk_va = '0;
    logic [19:0] hi_vpn = '0, lo_pfn = '0;
    logic [11:0] ctx_base = '0;
    logic        lk_hit, exc_pulse;
    logic [31:0] lk_pa, exc_vec, bad_va, ctx_word;
    logic [3:0]  rand_idx;
    logic [1:0]  exc_code;

    xlat_buffer u_xlat_buffer (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_store(lk_store), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .hi_we(hi_we), .hi_vpn(hi_vpn), .lo_we(lo_we),
        .lo_pfn(lo_pfn), .lo_valid(lo_valid), .lo_dirty(lo_dirty), .wr_rand(wr_rand),
        .ctx_we(ctx_we), .ctx_base(ctx_base), .rand_idx(rand_idx), .exc_pulse(exc_pulse),
        .exc_code(exc_code), .exc_vec(exc_vec), .bad_va(bad_va), .ctx_word(ctx_word)
    );

    always #5 clk = ~clk;

    typedef struct { bit v; bit d; bit [19:0] vpn; bit [19:0] pfn; } ment_t;
    ment_t     m [16];
    int        m_rand = 15;
    bit [19:0] p_vpn, p_pfn;
    bit        p_v, p_d;
    bit [31:0] m_bad;
    bit [11:0] m_base;
    int        total = 0, bad = 0;
    bit        done = 0;

    function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic idle();
        lk_req = 0; lk_store = 0; hi_we = 0; lo_we = 0; wr_rand = 0; ctx_we = 0;
    endtask

    function automatic int next_rand(int r);
        return (r == 0) ? 15 : r - 1;
    endfunction

    // One clock: check combinational outputs, update the model, check registered outputs
    task automatic step(string tag);
        int        mi;
        bit        hit_e;
        bit [31:0] pa_e, vec_e;
        int        code_e;
        string     ct;
        #2;
        mi = -1;
        for (int i = 0; i < 16; i++)
            if (mi < 0 && m[i].vpn == lk_va[31:12] && !(wr_rand && i == m_rand)) mi = i;
        hit_e  = lk_req && (mi >= 0) && m[mi < 0 ? 0 : mi].v;
        pa_e   = hit_e ? {m[mi].pfn, lk_va[11:0]} : 32'h0;
        code_e = 0;
        if (lk_req && rst_n) begin
            if (mi < 0)                        code_e = 1;
            else if (!m[mi].v)                 code_e = 2;
            else if (lk_store && !m[mi].d)     code_e = 3;
        end
        if (lk_req) begin
            chk(lk_hit == hit_e, {tag, "/R1 hit"}, 32'(lk_hit), 32'(hit_e));
            chk(lk_pa == pa_e, {tag, "/R1 pa"}, lk_pa, pa_e);
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m[i] = '{0, 0, 20'h0, 20'h0};
            p_vpn = 0; p_pfn = 0; p_v = 0; p_d = 0; m_bad = 0; m_base = 0; m_rand = 15;
        end else begin
            if (wr_rand) m[m_rand] = '{p_v, p_d, p_vpn, p_pfn};
            if (hi_we) p_vpn = hi_vpn;
            if (lo_we) begin p_pfn = lo_pfn; p_v = lo_valid; p_d = lo_dirty; end
            if (code_e == 1 || code_e == 2) m_bad = lk_va;
            if (ctx_we) m_base = ctx_base;
            m_rand = next_rand(m_rand);
        end
        @(negedge clk);
        vec_e = (code_e == 0) ? 32'h0 : (code_e == 1) ? 32'h8000_0000 : 32'h8000_0180;
        ct = (code_e == 1) ? "/R2" : (code_e == 2) ? "/R6" : (code_e == 3) ? "/R7" : "/R10";
        chk(exc_pulse == (code_e != 0), {tag, "/R10 pulse"}, 32'(exc_pulse), 32'(code_e != 0));
        chk(exc_code == 2'(code_e), {tag, ct, " code"}, 32'(exc_code), 32'(code_e));
        chk(exc_vec == vec_e, {tag, ct, " vec"}, exc_vec, vec_e);
        chk(bad_va == m_bad, {tag, "/R11 bad_va"}, bad_va, m_bad);
        chk(ctx_word == {m_base, m_bad[31:14], 2'b00}, {tag, "/R3 ctx"}, ctx_word,
            {m_base, m_bad[31:14], 2'b00});
        chk(rand_idx == 4'(m_rand), {tag, "/R5 rand"}, 32'(rand_idx), 32'(m_rand));
    endtask

    task automatic lookup(bit [31:0] va, bit st, string tag);
        idle(); lk_req = 1; lk_va = va; lk_store = st; step(tag);
    endtask

    task automatic load_pend(bit [19:0] vpn, bit [19:0] pfn, bit v, bit d, string tag);
        idle(); hi_we = 1; hi_vpn = vpn; lo_we = 1; lo_pfn = pfn; lo_valid = v; lo_dirty = d;
        step(tag);
    endtask

    // R4: load pending, then install at the counter slot
    task automatic fill(bit [19:0] vpn, bit [19:0] pfn, bit v, bit d, output int slot);
        load_pend(vpn, pfn, v, d, "R4");
        idle(); wr_rand = 1; slot = m_rand; step("R4");
    endtask

    function automatic bit dup_free(bit [19:0] vpn, int target);
        for (int i = 0; i < 16; i++)
            if (i != target && m[i].vpn == vpn) return 0;
        return 1;
    endfunction

    initial begin
        #(200000 * 10);
        chk(0, "watchdog", 32'h0, 32'h1);
        summary();
    end

    initial begin
        int s;
        int op;
        void'($urandom(32'd1234));
        idle();
        @(negedge clk);
        rst_n = 0;
        repeat (3) step("reset");
        rst_n = 1;
        chk(rand_idx == 4'd15, "R5 reset rand", 32'(rand_idx), 32'd15);
        chk(exc_pulse == 1'b0, "R10 reset pulse", 32'(exc_pulse), 32'd0);
        // R8: nothing hits after reset
        lookup(32'h1234_5678, 0, "R8");
        lookup(32'h0000_0abc, 0, "R8 vpn0");
        // R1 / R7: install and translate
        fill(20'h1A301, 20'hCAFE1, 1, 0, s);
        lookup(32'h1A30_1F0C, 0, "R1");
        lookup(32'h1A30_1004, 1, "R7");
        // R6: invalid entry
        fill(20'h1A302, 20'h00042, 0, 1, s);
        lookup(32'h1A30_2010, 0, "R6");
        // R3: base write then refill
        idle(); ctx_we = 1; ctx_base = 12'hA5C; step("R3");
        lookup(32'hFFFF_C123, 0, "R2");
        // R9: lookup while its slot is overwritten
        fill(20'h1A303, 20'h12345, 1, 1, s);
        load_pend(20'h1A3FF, 20'h77777, 1, 1, "R9");
        idle();
        while (m_rand != s) step("R5 wait");
        lk_req = 1; lk_va = 32'h1A30_3555; wr_rand = 1; step("R9");
        lookup(32'h1A3F_F000, 0, "R9 after");
        // Random mix
        for (int it = 0; it < 600; it++) begin
            op = $urandom % 4;
            case (op)
                0: begin
                    bit [19:0] vpn = {15'h0D18, 5'($urandom)};
                    if (dup_free(vpn, next_rand(m_rand)) && dup_free(vpn, next_rand(next_rand(m_rand))))
                        fill(vpn, 20'($urandom), 1'($urandom % 4 != 0), 1'($urandom), s);
                    else begin idle(); step("R5 idle"); end
                end
                1: begin
                    int k = $urandom % 16;
                    lookup({m[k].vpn, 12'($urandom)}, 1'($urandom), "rnd hit");
                end
                2: lookup({15'h0D18, 5'($urandom), 12'($urandom)}, 1'($urandom), "rnd");
                default: begin
                    idle(); ctx_we = 1; ctx_base = 12'($urandom);
                    lk_req = 1'($urandom); lk_va = $urandom; lk_store = 1'($urandom);
                    step("R3 rnd");
                end
            endcase
        end
        idle();
        step("end");
        summary();
    end
endmodule